// File: doc/BRIEF.md
# Triggered Multichannel Frame Capture Buffer

This block records fixed-length frames from eight parallel ADC sample streams. When a trigger is accepted, either from an external pin or from a software write, the block stores a run of consecutive samples from every channel. The run starts with the sample present in the cycle the trigger is accepted. Each 10-bit sample is cut to its upper nine bits. Two channels are packed into each 18-bit memory word, and the word is written into one of four synchronous dual-ported banks. Each frame fills one contiguous, block-aligned address range. The write pointer steps one frame per accepted trigger and wraps at the bank depth.

When the last word of a frame has been written, a descriptor is pushed into a FIFO. The descriptor holds the frame's start address and its event number. A small register port lets a host read status and the head descriptor, pop descriptors, raise a software trigger, read any bank word and read a fixed firmware version. Host reads proceed while capture continues. A frame's address block is reserved until its descriptor is popped. A trigger that would overwrite a reserved block is dropped and raises a sticky overflow flag.

The defaults are 32 samples per frame and 256 words per bank, which keeps elaboration small. The parameters scale to 256-sample frames in 64K-word banks, and event numbers wrap at 2^16.

Top module: `cap_frame_buf`

## Requirements
- R1: After reset, STATUS (register 1) reads 0x1. Its bits are bit0 descriptor FIFO empty, bit1 FIFO full, bit2 overflow and bit3 capturing.
- R2: A trigger accepted while idle captures FRAME_LEN consecutive samples per channel, starting with the sample present in the accept cycle. An external trigger is accepted in the cycle it is high. A software trigger (bit0 written to CTRL, register 0) is accepted in the following cycle. STATUS bit3 is set while a frame is being captured.
- R3: Bank b holds channels 2b and 2b+1. Word bits 8:0 hold bits 9:1 of channel 2b, and bits 17:9 hold bits 9:1 of channel 2b+1.
- R4: Sample i of a frame is stored at start address + i. The first frame starts at 0, and each accepted frame starts FRAME_LEN words after the previous one, modulo the bank depth.
- R5: When a frame's last sample is written, a descriptor is queued. DESC (register 2) shows the head descriptor, with the start address in bits 15:0 and the event number in bits 31:16. Event numbers start at 0 and increase by one per accepted trigger.
- R6: A trigger that arrives while a frame is being captured is ignored. It produces no descriptor, does not restart the frame and consumes no event number.
- R7: When every block holds an unpopped frame, a trigger is ignored and STATUS bit2 is set and stays set. After a pop, the next trigger is accepted into the freed block.
- R8: Writing bit1 to CTRL removes the head descriptor. A pop while the FIFO is empty has no effect.
- R9: RDADDR (register 3, bank in bits 17:16, word address in the low bits) selects a word. The word can be read from RDDATA (register 4) two cycles later, and reads work while a capture is running.
- R10: VERSION (register 5) reads 0x00010203.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; host port is synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_data | input | NCH*SMP_W (80) | Channel c sample in bits c*SMP_W +: SMP_W |
| ext_trig | input | 1 | External trigger, one cycle per request |
| host_sel | input | 1 | Host register access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after a read strobe |

## Verification
The embedded assertions rely on the host popping only through the CTRL register and on FRAME_LEN being a power of two no smaller than two. Under those conditions the reserved-block count can never exceed the number of blocks, and a descriptor push can never meet a full FIFO. The bench keeps within this by using only register writes for pops and software triggers. Its ADC streams are seeded pseudo-random functions of the cycle number, and its random idle gaps always let a frame finish before the next intended trigger. The exception is the deliberate mid-frame trigger that exercises R6.

// File: rtl/cap_pkg.sv
// Package: shared register indices, descriptor layout and version constant
// for the frame capture buffer. Assumes pointers fit in 16 bits.
package cap_pkg;
    localparam int          EVT_W      = 16;
    localparam logic [31:0] FW_VERSION = 32'h0001_0203;

    typedef enum logic [2:0] {
        REG_CTRL    = 3'd0,
        REG_STATUS  = 3'd1,
        REG_DESC    = 3'd2,
        REG_RDADDR  = 3'd3,
        REG_RDDATA  = 3'd4,
        REG_VERSION = 3'd5
    } reg_sel_e;

    // Frame descriptor; layout equals the DESC register view.
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [15:0]      ptr;
    } desc_t;
endpackage

// File: rtl/cap_bank.sv
// Module: cap_bank
// Synchronous dual-ported RAM with one write port and one registered read port.
// Assumes: no read/write collision ordering is relied upon.
module cap_bank #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port: store one packed word per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port: register the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cap_desc_fifo.sv
// Module: cap_desc_fifo
// Show-ahead FIFO of frame descriptors. Assumes DEPTH is a power of two
// and that the caller never pushes when full nor pops when empty.
module cap_desc_fifo
    import cap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  desc_t din,
    input  logic  pop,
    output desc_t dout,
    output logic  empty,
    output logic  full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    desc_t          mem [DEPTH];
    logic [PW-1:0]  wp_q, rp_q;
    logic [CW-1:0]  cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign dout  = mem[rp_q];

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full)
        else $error("descriptor pushed into full FIFO");
    p_pop_valid_r8: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty)
        else $error("descriptor popped from empty FIFO");
endmodule

// File: rtl/cap_seq.sv
// Module: cap_seq
// Trigger acceptance and frame sequencing: write pointer, frame index,
// event counter, block reservation count and overflow flag.
// Assumes FRAME_LEN is a power of two >= 2 and pop is pre-qualified.
module cap_seq
    import cap_pkg::*;
#(
    parameter int FRAME_LEN = 32,
    parameter int AW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          pop,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          push,
    output desc_t         push_desc,
    output logic          busy,
    output logic          ovf
);
    localparam int NBLK  = (1 << AW) / FRAME_LEN;
    localparam int OCC_W = $clog2(NBLK + 1);
    localparam int FL_W  = $clog2(FRAME_LEN);

    logic             busy_q, ovf_q;
    logic [FL_W-1:0]  idx_q;
    logic [AW-1:0]    base_q, wptr_q;
    logic [EVT_W-1:0] evt_q, fevt_q;
    logic [OCC_W-1:0] occ_q;
    logic             room, start, blocked, last;

    assign room    = (occ_q != OCC_W'(NBLK));
    assign start   = trig && !busy_q && room;
    assign blocked = trig && !busy_q && !room;
    assign last    = busy_q && (idx_q == FL_W'(FRAME_LEN - 1));

    assign wr_en     = start || busy_q;
    assign wr_addr   = start ? wptr_q : (base_q + AW'(idx_q));
    assign push      = last;
    assign push_desc = '{evt: fevt_q, ptr: 16'(base_q)};
    assign busy      = busy_q;
    assign ovf       = ovf_q;

    // Frame sequencing: begin on accepted trigger, finish after FRAME_LEN words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
            wptr_q <= '0;
            evt_q  <= '0;
            fevt_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= FL_W'(1);
            base_q <= wptr_q;
            wptr_q <= wptr_q + AW'(FRAME_LEN);
            fevt_q <= evt_q;
            evt_q  <= evt_q + 1'b1;
        end else if (busy_q) begin
            idx_q <= idx_q + 1'b1;
            if (last) busy_q <= 1'b0;
        end
    end

    // Block reservation count: taken on accept, released on descriptor pop.
    always_ff @(posedge clk) begin
        if (!rst_n)             occ_q <= '0;
        else if (start && !pop) occ_q <= occ_q + 1'b1;
        else if (pop && !start) occ_q <= occ_q - 1'b1;
    end

    // Sticky overflow on a trigger refused for lack of a free block.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (blocked) ovf_q <= 1'b1;
    end

    p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n) occ_q <= OCC_W'(NBLK))
        else $error("reserved blocks exceed capacity");
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n) ovf_q |=> ovf_q)
        else $error("overflow flag cleared");
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_desc.ptr[FL_W-1:0] == '0))
        else $error("frame start not block aligned");
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n) push |=> !busy_q)
        else $error("still capturing after last sample");
endmodule

// File: rtl/cap_frame_buf.sv
// Module: cap_frame_buf (top)
// Triggered multichannel frame capture into channel-paired banks with a
// descriptor FIFO and a host register port. Assumes the host port shares
// the sample clock and NCH is a multiple of 4 with 16-bit pointers or less.
module cap_frame_buf
    import cap_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int SMP_W     = 10,
    parameter int FRAME_LEN = 32,
    parameter int BANK_AW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*SMP_W-1:0] adc_data,
    input  logic                 ext_trig,
    input  logic                 host_sel,
    input  logic                 host_we,
    input  logic [2:0]           host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata
);
    localparam int NBANK  = NCH / 2;
    localparam int KEEP_W = SMP_W - 1;
    localparam int WORD_W = 2 * KEEP_W;
    localparam int NBLK   = (1 << BANK_AW) / FRAME_LEN;
    localparam int BSEL_W = $clog2(NBANK);

    logic                 wr_ctrl, soft_q, trig, pop_req;
    logic                 wr_en, push, busy, ovf, f_empty, f_full;
    logic [BANK_AW-1:0]   wr_addr;
    desc_t                push_desc, head;
    logic [BANK_AW-1:0]   rd_word_q;
    logic [BSEL_W-1:0]    rd_bank_q;
    logic [WORD_W-1:0]    bank_q [NBANK];

    assign wr_ctrl = host_sel && host_we && (host_addr == REG_CTRL);
    assign pop_req = wr_ctrl && host_wdata[1] && !f_empty;
    assign trig    = ext_trig || soft_q;

    // Software trigger: one-cycle pulse after a CTRL write with bit0 set.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_q <= 1'b0;
        else        soft_q <= wr_ctrl && host_wdata[0];
    end

    // Host read address latch: bank select and word address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word_q <= '0;
            rd_bank_q <= '0;
        end else if (host_sel && host_we && host_addr == REG_RDADDR) begin
            rd_word_q <= host_wdata[BANK_AW-1:0];
            rd_bank_q <= host_wdata[16 +: BSEL_W];
        end
    end

    cap_seq #(.FRAME_LEN(FRAME_LEN), .AW(BANK_AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .pop       (pop_req),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .push      (push),
        .push_desc (push_desc),
        .busy      (busy),
        .ovf       (ovf)
    );

    cap_desc_fifo #(.DEPTH(NBLK)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (push_desc),
        .pop   (pop_req),
        .dout  (head),
        .empty (f_empty),
        .full  (f_full)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [WORD_W-1:0] word;
        assign word = {adc_data[(2*b+1)*SMP_W+1 +: KEEP_W],
                       adc_data[(2*b)*SMP_W+1 +: KEEP_W]};
        cap_bank #(.AW(BANK_AW), .DW(WORD_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (word),
            .raddr (rd_word_q),
            .rdata (bank_q[b])
        );
    end

    // Host read mux, registered: one cycle from strobe to data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_sel && !host_we) begin
            case (host_addr)
                REG_STATUS:  host_rdata <= {28'd0, busy, ovf, f_full, f_empty};
                REG_DESC:    host_rdata <= head;
                REG_RDDATA:  host_rdata <= 32'(bank_q[rd_bank_q]);
                REG_VERSION: host_rdata <= FW_VERSION;
                default:     host_rdata <= '0;
            endcase
        end
    end

    p_full_means_ovf_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_full && trig && !busy) |=> ovf)
        else $error("trigger on full buffer did not flag overflow");
    p_no_write_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_full && !busy) |-> !wr_en)
        else $error("write into reserved block");
endmodule

// File: tb/sim_cap_frame_buf.sv
module sim_cap_frame_buf;
    localparam int NCH = 8, SMP_W = 10, FL = 32, AW = 8;
    localparam int NBLK = (1 << AW) / FL;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH*SMP_W-1:0] adc_data = '0;
    logic                 ext_trig = 1'b0;
    logic                 host_sel = 1'b0, host_we = 1'b0;
    logic [2:0]           host_addr = '0;
    logic [31:0]          host_wdata = '0;
    logic [31:0]          host_rdata;

    int cyc = 0;
    int n_run = 0, n_fail = 0;
    int off;
    int t0s [16];
    bit done = 0;

    always #4 clk = ~clk;

    cap_frame_buf #(.NCH(NCH), .SMP_W(SMP_W), .FRAME_LEN(FL), .BANK_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .ext_trig(ext_trig),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic int smp(int ch, int t);
        return (t * 37 + ch * 113 + off) & 1023;
    endfunction

    function automatic int exp_word(int b, int t);
        return ((smp(2*b+1, t) >> 1) << 9) | (smp(2*b, t) >> 1);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk)
        for (int ch = 0; ch < NCH; ch++) adc_data[ch*SMP_W +: SMP_W] <= 10'(smp(ch, cyc));

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic hwrite(int a, int d);
        host_sel = 1; host_we = 1; host_addr = 3'(a); host_wdata = d;
        tick();
        host_sel = 0; host_we = 0;
    endtask

    task automatic hread(int a, output int d);
        host_sel = 1; host_we = 0; host_addr = 3'(a);
        tick();
        d = host_rdata;
        host_sel = 0;
    endtask

    task automatic rdword(int b, int addr, output int d);
        hwrite(3, (b << 16) | addr);
        tick();
        hread(4, d);
    endtask

    task automatic ext_pulse(output int t0);
        ext_trig = 1; t0 = cyc;
        tick();
        ext_trig = 0;
    endtask

    task automatic soft_pulse(output int t0);
        t0 = cyc + 1;
        hwrite(0, 1);
    endtask

    task automatic chk_word(string req, int ptr, int i, int t0);
        int d;
        for (int b = 0; b < NCH/2; b++) begin
            rdword(b, (ptr + i) % (1 << AW), d);
            chk(d == exp_word(b, t0 + i), req, d, exp_word(b, t0 + i));
        end
    endtask

    task automatic chk_desc(string req, int ptr, int evt);
        int d;
        hread(2, d);
        chk(d == ((evt << 16) | ptr), req, d, (evt << 16) | ptr);
    endtask

    initial begin
        int d;
        off = int'($urandom(32'd2024) & 1023);
        tick(5);
        rst_n = 1;
        tick();

        // R1 reset state, R10 version
        hread(1, d); chk(d == 32'h1, "R1", d, 1);
        hread(5, d); chk(d == 32'h0001_0203, "R10", d, 32'h0001_0203);

        // R2/R3/R4/R5 first external frame, R6 mid-frame trigger ignored
        tick($urandom_range(1, 6));
        ext_pulse(t0s[0]);
        tick(2);
        hread(1, d); chk(d == 32'h9, "R2 capturing", d, 9);
        ext_pulse(d);
        tick(FL + 2);
        chk_desc("R5 first desc", 0, 0);
        for (int i = 0; i < FL; i++) chk_word("R3 frame0", 0, i, t0s[0]);
        hwrite(0, 2);
        hread(1, d); chk(d == 32'h1, "R6 single descriptor", d, 1);

        // R2 software trigger, R4 pointer step, R6 event not consumed
        tick($urandom_range(1, 6));
        soft_pulse(t0s[1]);
        tick(FL + 2);
        chk_desc("R6 evt after ignore", FL, 1);
        chk_word("R2 soft start", FL, 0, t0s[1]);
        chk_word("R2 soft end", FL, FL - 1, t0s[1]);

        // R9 read frame1 while frame2 captures
        ext_pulse(t0s[2]);
        chk_word("R9 read during capture", FL, 5, t0s[1]);
        hread(1, d); chk(d[3] == 1'b1, "R9 still capturing", d, 8);
        tick(FL);
        chk_word("R4 frame2", 2*FL, $urandom_range(0, FL - 1), t0s[2]);

        // fill remaining blocks: frames 3..8 (frame 8 wraps to 0)
        for (int e = 3; e <= 8; e++) begin
            tick($urandom_range(1, 4));
            ext_pulse(t0s[e]);
            tick(FL + 2);
        end
        chk_word("R4 wrap frame8", 0, 3, t0s[8]);
        hread(1, d); chk(d == 32'h2, "R7 full", d, 2);

        // R7 refused trigger, sticky overflow, existing data kept
        ext_pulse(d);
        tick(FL + 2);
        hread(1, d); chk(d == 32'h6, "R7 overflow", d, 6);
        chk_word("R7 data kept", 0, 3, t0s[8]);
        chk_desc("R7 head unchanged", FL, 1);

        // R8 pop frees block, next frame lands at freed block
        hwrite(0, 2);
        chk_desc("R8 pop head", 2*FL, 2);
        soft_pulse(t0s[9]);
        tick(FL + 2);
        chk_word("R7 reuse freed block", FL, 7, t0s[9]);
        hread(1, d); chk(d == 32'h6, "R7 sticky", d, 6);

        // R8 drain, then an empty pop has no effect
        for (int k = 0; k < NBLK; k++) hwrite(0, 2);
        hread(1, d); chk(d == 32'h5, "R8 drained", d, 5);
        hwrite(0, 2);
        hread(1, d); chk(d == 32'h5, "R8 empty pop", d, 5);
        ext_pulse(t0s[10]);
        tick(FL + 2);
        chk_desc("R8 after empty pop", 2*FL, 10);
        chk_word("R3 frame10", 2*FL, FL - 1, t0s[10]);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule